// File: doc/BRIEF.md
# Auto-Increment Register Pointer

This block is the register-file access controller that sits behind a byte-level serial slave. Once a slave address has been accepted, the bus front end signals `start`. It then hands over each received byte with `byteValid`, along with `rw` to mark a read or a write. The first write byte of a transaction is a control byte. Its low six bits select a register, bit 7 turns auto-increment on, and bit 6 must be clear. Every later byte writes the selected register, or reads it back on a read. The pointer then moves on under the active increment mode.

The increment mode combines the auto-increment flag from the control byte with a two-bit field held in bits 6:5 of the mode register at index 00h. Each mode wraps the pointer inside its own window of the register map:

- the whole map;
- only the brightness registers;
- only the two group registers;
- the brightness and group registers together.

A pointer beyond the register map, or a control byte with bit 6 set, is refused. Every following byte of that transaction is then refused as well. The register storage lives in the block, and reads come back through the same byte stream.

Top module: `autoinc_regport`

## Requirements
- R1: After reset all 39 registers hold 00h, the pointer is 00h and valid, the auto-increment flag is 0, and `ack` and `rdData` are 0.
- R2: The first write byte after `start` (or in the same cycle as `start`) is taken as the control byte. The pointer is loaded from its bits 5:0 and the auto-increment flag from bit 7. It is never stored into a register.
- R3: A control byte whose bits 5:0 exceed 26h, or whose bit 6 is 1, is not acknowledged. Later bytes are then not acknowledged, write nothing and read as 00h, until a good control byte arrives.
- R4: `ack` is registered. It is high in the cycle after an accepted byte, and it is 0 in every cycle that does not follow a byte.
- R5: With the auto-increment flag at 0, the pointer stays fixed across data bytes.
- R6: Flag 1 with mode field 00: the pointer steps through 00h to 26h and wraps from 26h to 00h.
- R7: Flag 1 with mode field 01: the pointer wraps from 19h to 02h. A pointer at or above 19h goes to 02h.
- R8: Flag 1 with mode field 10: the pointer wraps from 1Bh to 1Ah. A pointer below 1Ah steps up by one.
- R9: Flag 1 with mode field 11: the pointer wraps from 1Bh to 02h.
- R10: A read byte returns the addressed register on `rdData` in the cycle after the byte, and advances the pointer by the same rules as a write. `rdData` is 00h in every cycle without an acknowledged read.
- R11: Bit 7 of register 00h always reads as the current auto-increment flag. Writes to that bit are ignored.
- R12: The pointer and flag persist across transactions. A read transaction, which carries no control byte, starts at the retained pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse marking a newly addressed transaction |
| byteValid | input | 1 | A received or requested byte is present this cycle |
| rw | input | 1 | 1 = read byte, 0 = write byte |
| dataIn | input | 8 | Write byte (control or data) |
| ack | output | 1 | Byte accepted, one cycle after the byte |
| rdData | output | 8 | Read data, valid with `ack` after a read byte |

## Verification
The bound checker watches several properties on every cycle:

- `ack` never rises without a byte in the cycle before;
- a refused control byte is never acknowledged;
- a fixed pointer holds steady when the flag is clear;
- each mode's top-of-window wrap is taken;
- `rdData` stays zero whenever nothing is acknowledged;
- a valid pointer never leaves the map.

Other behaviours only the bench's scenarios can show. These are the stored and returned register values, the control byte never reaching storage, the read-only flag bit in register 00h, and a pointer carried across a read transaction.

// File: rtl/acp_pkg.sv
package acp_pkg;
  typedef struct packed {
    logic wrReg;
    logic rdReg;
    logic ackByte;
  } accStrobe_t;
endpackage

// File: rtl/acp_step.sv
module acp_step #(
  parameter int PTR_W  = 6,
  parameter int LAST   = 38,
  parameter int PWM_LO = 2,
  parameter int PWM_HI = 25,
  parameter int GRP_LO = 26,
  parameter int GRP_HI = 27
) (
  input  logic [PTR_W-1:0] ptr,
  input  logic             aif,
  input  logic [1:0]       aiMode,
  output logic [PTR_W-1:0] nextPtr
);
  localparam logic [PTR_W-1:0] LAST_P   = PTR_W'(LAST);
  localparam logic [PTR_W-1:0] PWM_LO_P = PTR_W'(PWM_LO);
  localparam logic [PTR_W-1:0] PWM_HI_P = PTR_W'(PWM_HI);
  localparam logic [PTR_W-1:0] GRP_LO_P = PTR_W'(GRP_LO);
  localparam logic [PTR_W-1:0] GRP_HI_P = PTR_W'(GRP_HI);

  logic [PTR_W-1:0] winLo, winHi;

  always_comb begin
    case (aiMode)
      2'b00:   begin winLo = '0;       winHi = LAST_P;   end
      2'b01:   begin winLo = PWM_LO_P; winHi = PWM_HI_P; end
      2'b10:   begin winLo = GRP_LO_P; winHi = GRP_HI_P; end
      default: begin winLo = PWM_LO_P; winHi = GRP_HI_P; end
    endcase
    if (!aif)              nextPtr = ptr;
    else if (ptr >= winHi) nextPtr = winLo;
    else                   nextPtr = ptr + 1'b1;
  end
endmodule

// File: rtl/acp_ctrl.sv
module acp_ctrl
  import acp_pkg::*;
#(
  parameter int PTR_W  = 6,
  parameter int LAST   = 38,
  parameter int PWM_LO = 2,
  parameter int PWM_HI = 25,
  parameter int GRP_LO = 26,
  parameter int GRP_HI = 27
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             byteValid,
  input  logic             rw,
  input  logic [7:0]       dataIn,
  input  logic [1:0]       aiMode,
  output logic [PTR_W-1:0] ptr,
  output logic             aif,
  output logic             ptrOk,
  output logic             expectCtrl,
  output accStrobe_t       stb
);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(LAST);

  logic             isCtrl, isData, ctrlGood;
  logic [PTR_W-1:0] nextPtr;
  logic [PTR_W-1:0] ctrlPtr;

  assign ctrlPtr  = dataIn[PTR_W-1:0];
  assign isCtrl   = byteValid & ~rw & (expectCtrl | start);
  assign isData   = byteValid & ~isCtrl;
  assign ctrlGood = (ctrlPtr <= LAST_P) & ~dataIn[6];

  acp_step #(
    .PTR_W(PTR_W), .LAST(LAST), .PWM_LO(PWM_LO), .PWM_HI(PWM_HI),
    .GRP_LO(GRP_LO), .GRP_HI(GRP_HI)
  ) u_step (
    .ptr(ptr), .aif(aif), .aiMode(aiMode), .nextPtr(nextPtr)
  );

  always_comb begin
    stb.wrReg   = isData & ~rw & ptrOk;
    stb.rdReg   = isData & rw & ptrOk;
    stb.ackByte = isCtrl ? ctrlGood : (isData & ptrOk);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr        <= '0;
      aif        <= 1'b0;
      ptrOk      <= 1'b1;
      expectCtrl <= 1'b0;
    end else begin
      if (isCtrl)     expectCtrl <= 1'b0;
      else if (start) expectCtrl <= 1'b1;

      if (isCtrl) begin
        ptr   <= ctrlPtr;
        aif   <= dataIn[7];
        ptrOk <= ctrlGood;
      end else if (isData && ptrOk) begin
        ptr <= nextPtr;
      end
    end
  end
endmodule

// File: rtl/acp_regs.sv
module acp_regs
  import acp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 39,
  parameter int PTR_W    = 6,
  parameter int MODE_IDX = 0,
  parameter int AI_LSB   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  accStrobe_t        stb,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              aif,
  input  logic [DATA_W-1:0] dataIn,
  output logic [1:0]        aiMode,
  output logic              ack,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [PTR_W-1:0] MODE_P = PTR_W'(MODE_IDX);
  localparam logic [PTR_W-1:0] CNT_P  = PTR_W'(NUM_REGS);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] rdWord;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = stb.wrReg && (ptr == PTR_W'(i));
    if (i == MODE_IDX) begin : g_mode
      always_ff @(posedge clk) begin
        if (!rstN)    regs[i] <= '0;
        else if (hit) regs[i] <= {1'b0, dataIn[DATA_W-2:0]};
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN)    regs[i] <= '0;
        else if (hit) regs[i] <= dataIn;
      end
    end
  end

  assign aiMode = regs[MODE_IDX][AI_LSB+1:AI_LSB];

  always_comb begin
    rdWord = '0;
    if (ptr < CNT_P) rdWord = regs[ptr];
    if (ptr == MODE_P) rdWord[DATA_W-1] = aif;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ack    <= 1'b0;
      rdData <= '0;
    end else begin
      ack    <= stb.ackByte;
      rdData <= stb.rdReg ? rdWord : '0;
    end
  end
endmodule

// File: rtl/autoinc_regport.sv
module autoinc_regport
  import acp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PTR_W    = 6,
  parameter int NUM_REGS = 39,
  parameter int PWM_LO   = 2,
  parameter int PWM_HI   = 25,
  parameter int GRP_LO   = 26,
  parameter int GRP_HI   = 27
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              byteValid,
  input  logic              rw,
  input  logic [DATA_W-1:0] dataIn,
  output logic              ack,
  output logic [DATA_W-1:0] rdData
);
  localparam int LAST = NUM_REGS - 1;

  accStrobe_t       stb;
  logic [PTR_W-1:0] ptr;
  logic             aif, ptrOk, expectCtrl;
  logic [1:0]       aiMode;

  acp_ctrl #(
    .PTR_W(PTR_W), .LAST(LAST), .PWM_LO(PWM_LO), .PWM_HI(PWM_HI),
    .GRP_LO(GRP_LO), .GRP_HI(GRP_HI)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .byteValid(byteValid), .rw(rw),
    .dataIn(dataIn), .aiMode(aiMode), .ptr(ptr), .aif(aif), .ptrOk(ptrOk),
    .expectCtrl(expectCtrl), .stb(stb)
  );

  acp_regs #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .PTR_W(PTR_W)
  ) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .ptr(ptr), .aif(aif), .dataIn(dataIn),
    .aiMode(aiMode), .ack(ack), .rdData(rdData)
  );
endmodule

// File: rtl/acp_checker.sv
module acp_checker #(
  parameter int PTR_W  = 6,
  parameter int LAST   = 38,
  parameter int PWM_LO = 2,
  parameter int PWM_HI = 25,
  parameter int GRP_LO = 26,
  parameter int GRP_HI = 27
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             byteValid,
  input logic             rw,
  input logic [7:0]       dataIn,
  input logic             ack,
  input logic [7:0]       rdData,
  input logic [PTR_W-1:0] ptr,
  input logic             aif,
  input logic             ptrOk,
  input logic             expectCtrl,
  input logic [1:0]       aiMode
);
  localparam logic [PTR_W-1:0] LAST_P   = PTR_W'(LAST);
  localparam logic [PTR_W-1:0] PWM_LO_P = PTR_W'(PWM_LO);
  localparam logic [PTR_W-1:0] PWM_HI_P = PTR_W'(PWM_HI);
  localparam logic [PTR_W-1:0] GRP_LO_P = PTR_W'(GRP_LO);
  localparam logic [PTR_W-1:0] GRP_HI_P = PTR_W'(GRP_HI);

  logic ctrlByte, dataByte, badCtrl;
  assign ctrlByte = byteValid && !rw && (expectCtrl || start);
  assign dataByte = byteValid && !ctrlByte;
  assign badCtrl  = (dataIn[PTR_W-1:0] > LAST_P) || dataIn[6];

  p_ack_needs_byte_r4: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> $past(byteValid));

  p_bad_ctrl_nack_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlByte && badCtrl) |=> !ack);

  p_valid_in_map_r3: assert property (@(posedge clk) disable iff (!rstN)
    ptrOk |-> (ptr <= LAST_P));

  p_rd_zero_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ack |-> (rdData == 8'h00));

  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dataByte && !aif) |=> $stable(ptr));

  p_full_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataByte && ptrOk && aif && aiMode == 2'b00 && ptr == LAST_P) |=> ptr == '0);

  p_pwm_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dataByte && ptrOk && aif && aiMode == 2'b01 && ptr == PWM_HI_P) |=> ptr == PWM_LO_P);

  p_grp_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dataByte && ptrOk && aif && aiMode == 2'b10 && ptr == GRP_HI_P) |=> ptr == GRP_LO_P);

  p_mix_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dataByte && ptrOk && aif && aiMode == 2'b11 && ptr == GRP_HI_P) |=> ptr == PWM_LO_P);
endmodule

bind autoinc_regport acp_checker #(
  .PTR_W(PTR_W), .LAST(NUM_REGS - 1), .PWM_LO(PWM_LO), .PWM_HI(PWM_HI),
  .GRP_LO(GRP_LO), .GRP_HI(GRP_HI)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .byteValid(byteValid), .rw(rw),
  .dataIn(dataIn), .ack(ack), .rdData(rdData), .ptr(ptr), .aif(aif),
  .ptrOk(ptrOk), .expectCtrl(expectCtrl), .aiMode(aiMode)
);

// File: tb/sim_autoinc_regport.sv
module sim_autoinc_regport;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, byteValid = 1'b0, rw = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic ack;
  logic [7:0] rdData;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  autoinc_regport u0 (
    .clk(clk), .rstN(rstN), .start(start), .byteValid(byteValid), .rw(rw),
    .dataIn(dataIn), .ack(ack), .rdData(rdData)
  );

  // {start, rw, data, expAck, expRd, req}
  localparam int NV = 46;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1,1'b0,8'h82,1'b1,8'h00,4'd2},  // R2 ctrl ptr 02 AI on
    {1'b0,1'b0,8'h11,1'b1,8'h00,4'd6},  // 02=11
    {1'b0,1'b0,8'h22,1'b1,8'h00,4'd6},  // 03=22
    {1'b1,1'b0,8'h02,1'b1,8'h00,4'd2},  // ctrl ptr 02 AI off
    {1'b0,1'b1,8'h00,1'b1,8'h11,4'd5},  // R5 read 02
    {1'b0,1'b1,8'h00,1'b1,8'h11,4'd5},  // R5 still 02
    {1'b1,1'b0,8'h42,1'b0,8'h00,4'd3},  // R3 bit6 set
    {1'b0,1'b0,8'h55,1'b0,8'h00,4'd3},  // R3 refused write
    {1'b0,1'b1,8'h00,1'b0,8'h00,4'd3},  // R3 refused read
    {1'b1,1'b0,8'h27,1'b0,8'h00,4'd3},  // R3 reserved pointer
    {1'b1,1'b0,8'h83,1'b1,8'h00,4'd2},  // ctrl ptr 03
    {1'b0,1'b1,8'h00,1'b1,8'h22,4'd10}, // R10 read 03
    {1'b0,1'b1,8'h00,1'b1,8'h00,4'd10}, // R10 read 04
    {1'b1,1'b0,8'h80,1'b1,8'h00,4'd2},  // ctrl ptr 00
    {1'b0,1'b0,8'h20,1'b1,8'h00,4'd7},  // mode field 01
    {1'b1,1'b0,8'h99,1'b1,8'h00,4'd2},  // ctrl ptr 19
    {1'b0,1'b0,8'hAA,1'b1,8'h00,4'd7},  // 19=AA, wrap to 02
    {1'b0,1'b0,8'hBB,1'b1,8'h00,4'd7},  // 02=BB
    {1'b1,1'b0,8'h19,1'b1,8'h00,4'd2},
    {1'b0,1'b1,8'h00,1'b1,8'hAA,4'd7},  // R7 read 19
    {1'b1,1'b0,8'h80,1'b1,8'h00,4'd2},
    {1'b0,1'b1,8'h00,1'b1,8'hA0,4'd11}, // R11 flag in bit 7
    {1'b0,1'b1,8'h00,1'b1,8'h00,4'd10}, // read 01
    {1'b0,1'b1,8'h00,1'b1,8'hBB,4'd7},  // R7 read 02 (wrap stored BB)
    {1'b1,1'b0,8'h80,1'b1,8'h00,4'd2},
    {1'b0,1'b0,8'h40,1'b1,8'h00,4'd8},  // mode field 10
    {1'b1,1'b0,8'h9A,1'b1,8'h00,4'd2},
    {1'b0,1'b0,8'h01,1'b1,8'h00,4'd8},  // 1A=01
    {1'b0,1'b0,8'h02,1'b1,8'h00,4'd8},  // 1B=02 wrap to 1A
    {1'b0,1'b0,8'h03,1'b1,8'h00,4'd8},  // 1A=03
    {1'b0,1'b1,8'h00,1'b1,8'h02,4'd8},  // R8 read 1B
    {1'b0,1'b1,8'h00,1'b1,8'h03,4'd8},  // R8 read 1A after wrap
    {1'b1,1'b0,8'h80,1'b1,8'h00,4'd2},
    {1'b0,1'b0,8'h60,1'b1,8'h00,4'd9},  // mode field 11
    {1'b1,1'b0,8'h9B,1'b1,8'h00,4'd2},
    {1'b0,1'b1,8'h00,1'b1,8'h02,4'd9},  // R9 read 1B
    {1'b0,1'b1,8'h00,1'b1,8'hBB,4'd9},  // R9 wrapped to 02
    {1'b1,1'b0,8'h80,1'b1,8'h00,4'd2},
    {1'b0,1'b0,8'h00,1'b1,8'h00,4'd6},  // mode field 00
    {1'b1,1'b0,8'hA6,1'b1,8'h00,4'd2},
    {1'b0,1'b0,8'h77,1'b1,8'h00,4'd6},  // 26=77 wrap to 00
    {1'b0,1'b1,8'h00,1'b1,8'h80,4'd6},  // R6 read 00
    {1'b1,1'b0,8'hA6,1'b1,8'h00,4'd2},
    {1'b0,1'b1,8'h00,1'b1,8'h77,4'd6},  // R6 read 26
    {1'b1,1'b1,8'h00,1'b1,8'h80,4'd12}, // R12 read transaction keeps ptr 00
    {1'b0,1'b1,8'h00,1'b1,8'h00,4'd12}  // R12 continues at 01
  };

  task automatic check(input logic a, input logic [7:0] d,
                       input logic ea, input logic [7:0] ed, input int req);
    checks++;
    if (a !== ea || d !== ed) begin
      errors++;
      $display("FAIL R%0d: ack=%0b rdData=%02h expected ack=%0b rdData=%02h",
               req, a, d, ea, ed);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic doByte(input logic r, input logic [7:0] d,
                        input logic ea, input logic [7:0] ed, input int req);
    @(negedge clk); byteValid = 1'b1; rw = r; dataIn = d;
    @(negedge clk); byteValid = 1'b0; rw = 1'b0;
    check(ack, rdData, ea, ed, req);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ack, rdData, 1'b0, 8'h00, 1);           // R1 reset outputs
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][22]) pulseStart();
      doByte(VEC[i][21], VEC[i][20:13], VEC[i][12], VEC[i][11:4], int'(VEC[i][3:0]));
    end

    // R1: reset clears storage, pointer and flag
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(ack, rdData, 1'b0, 8'h00, 1);
    rstN = 1'b1;
    doByte(1'b1, 8'h00, 1'b1, 8'h00, 1);          // R1 ptr 00, flag 0
    pulseStart(); doByte(1'b0, 8'h26, 1'b1, 8'h00, 1);
    doByte(1'b1, 8'h00, 1'b1, 8'h00, 1);          // R1 reg 26 was 77

    // R4: start alone produces no ack
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(ack, rdData, 1'b0, 8'h00, 4);

    // R2: control byte not stored in its own register
    doByte(1'b0, 8'h85, 1'b1, 8'h00, 2);
    pulseStart(); doByte(1'b0, 8'h05, 1'b1, 8'h00, 2);
    doByte(1'b1, 8'h00, 1'b1, 8'h00, 2);

    // R7: pointer above the brightness window goes to 02
    pulseStart(); doByte(1'b0, 8'h82, 1'b1, 8'h00, 7);
    doByte(1'b0, 8'h5C, 1'b1, 8'h00, 7);
    pulseStart(); doByte(1'b0, 8'h80, 1'b1, 8'h00, 7);
    doByte(1'b0, 8'h20, 1'b1, 8'h00, 7);
    pulseStart(); doByte(1'b0, 8'hA0, 1'b1, 8'h00, 7);
    doByte(1'b1, 8'h00, 1'b1, 8'h00, 7);
    doByte(1'b1, 8'h00, 1'b1, 8'h5C, 7);

    // R11: write to bit 7 of register 00 ignored
    pulseStart(); doByte(1'b0, 8'h00, 1'b1, 8'h00, 11);
    doByte(1'b0, 8'hA0, 1'b1, 8'h00, 11);
    doByte(1'b1, 8'h00, 1'b1, 8'h20, 11);

    summary();
  end
endmodule